// File: doc/BRIEF.md
# Set-Associative Address Translator with Access Rights

This block turns a virtual address into a physical address through a small set-associative store of recent page mappings. The page-number part of the address is divided into a set index, which picks one set, and a tag, which is compared against every valid way of that set in parallel. When a way matches, the stored physical page number is joined to the untouched page offset. The access kind and privilege level are also checked against the rights stored with that mapping. A matching way whose rights do not allow the access yields a protection fault instead of an address.

When no way matches, the block reports a miss and raises a refill request carrying the missing page number. An outside agent then supplies the mapping through the fill port. A fill goes to a way that already holds the same page if there is one. Otherwise it goes to the lowest-numbered empty way, and failing that to the way named by a per-set rotating pointer. A flush input drops every mapping in a single cycle. Lookups are combinational and their results are registered, so each response appears exactly one clock after its request.

Top module: `vtrans_tlb`

## Requirements
- R1: A request accepted in cycle k produces a response with `rsp_valid` high in cycle k+1. In a cycle that follows no request, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault`, `refill_req`, `rsp_paddr` and `refill_vpn` are all zero.
- R2: The low 12 bits of `req_vaddr` are the page offset, bits [13:12] select one of 4 sets and bits [31:14] are the tag. The tag is compared against both ways of the selected set, and only valid ways take part.
- R3: Every response has exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` set.
- R4: On a hit, `rsp_paddr` equals the stored 20-bit physical page number in bits [31:12] and the request's offset, unchanged, in bits [11:0].
- R5: The rights field `fill_perm` has bit 0 = read, bit 1 = write, bit 2 = execute and bit 3 = user-accessible. `req_kind` is 00 for read, 01 for write and 10 for execute; 11 is reserved and always faults on a match. The access needs its matching right, and a request with `req_user` high also needs the user bit. A match that fails these checks gives `rsp_fault` with `rsp_paddr` zero.
- R6: On a miss, `refill_req` is high, `refill_vpn` equals `req_vaddr[31:12]` and `rsp_paddr` is zero.
- R7: A fill accepted in cycle k is visible to lookups from cycle k+1 on. A lookup made in cycle k itself sees the contents from before the fill.
- R8: A fill whose page number already sits in a valid way of its set overwrites that way, so no page is ever held twice.
- R9: Otherwise the fill goes to the lowest-numbered invalid way of the set. If the set is full, it goes to the way named by that set's rotating pointer. The pointer is 0 after reset and advances, wrapping, only when such a replacement occurs.
- R10: `flush` invalidates every way at the next clock edge. A fill in the same cycle is discarded, and a lookup in the same cycle still sees the old contents.
- R11: After reset, no way is valid and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| req_user | input | 1 | Request comes from user privilege |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching mapping held |
| rsp_fault | output | 1 | Mapping held but access rights violated |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| refill_req | output | 1 | Mapping needed from outside |
| refill_vpn | output | 20 | Page number to fetch on a miss, else zero |
| fill_valid | input | 1 | Write a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_ppn | input | 20 | Physical page number of the mapping |
| fill_perm | input | 4 | Rights: bit0 read, bit1 write, bit2 execute, bit3 user |
| flush | input | 1 | Invalidate all mappings |

## Verification
The assertions assume that every input is driven to a known value on every cycle after reset. They also assume that a fill and a lookup of the same page in consecutive cycles mean the fill should be visible, so a flush is never expected to undo a fill in the same cycle. The stimulus draws page numbers from a pool of sixteen, which crowds four tags into every two-way set and forces hits, duplicate fills and rotating replacement. Flushes are kept rare, so the store fills up between them.

// File: rtl/vtrans_pkg.sv
package vtrans_pkg;

  localparam int PERM_W = 4;
  localparam int PB_RD  = 0;
  localparam int PB_WR  = 1;
  localparam int PB_EX  = 2;
  localparam int PB_USR = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  // Decide whether the stored rights allow the access.
  function automatic logic rights_allow(input logic [PERM_W-1:0] perm,
                                        input logic [1:0]        kind,
                                        input logic              user);
    logic ok;
    case (acc_kind_e'(kind))
      ACC_READ:  ok = perm[PB_RD];
      ACC_WRITE: ok = perm[PB_WR];
      ACC_EXEC:  ok = perm[PB_EX];
      default:   ok = 1'b0;
    endcase
    if (user && !perm[PB_USR]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/vtrans_store.sv
module vtrans_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 18,
  parameter int PPN_W  = 20,
  parameter int PERM_W = 4,
  parameter int WAY_W  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [WAYS-1:0]               rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
  output logic [WAYS-1:0][PPN_W-1:0]    rd_ppn,
  output logic [WAYS-1:0][PERM_W-1:0]   rd_perm,
  input  logic                          fill_en,
  input  logic                          flush_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [TAG_W-1:0]              fill_tag,
  input  logic [PPN_W-1:0]              fill_ppn,
  input  logic [PERM_W-1:0]             fill_perm
);

  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   vld_d [SETS];
  logic [WAY_W-1:0]  ptr_q [SETS];
  logic [WAY_W-1:0]  ptr_d [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];

  logic              wr_en;
  logic              dup_found;
  logic [WAY_W-1:0]  dup_way;
  logic              inv_found;
  logic [WAY_W-1:0]  inv_way;
  logic [WAY_W-1:0]  victim;
  logic              rot_adv;

  assign wr_en = fill_en & ~flush_en;

  // Victim choice: same page first, then lowest empty way, then pointer.
  always_comb begin
    dup_found = 1'b0;
    dup_way   = '0;
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_q[fill_idx][w] && (tag_q[fill_idx][w] == fill_tag)) begin
        dup_found = 1'b1;
        dup_way   = WAY_W'(w);
      end
      if (!vld_q[fill_idx][w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
    if (dup_found)      victim = dup_way;
    else if (inv_found) victim = inv_way;
    else                victim = ptr_q[fill_idx];
    rot_adv = wr_en & ~dup_found & ~inv_found;
  end

  // Next state of valid bits and rotating pointers.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
      ptr_d[s] = ptr_q[s];
    end
    if (flush_en) begin
      for (int s = 0; s < SETS; s++) vld_d[s] = '0;
    end else if (wr_en) begin
      vld_d[fill_idx][victim] = 1'b1;
    end
    if (rot_adv) begin
      if (ptr_q[fill_idx] == WAY_W'(WAYS-1)) ptr_d[fill_idx] = '0;
      else                                   ptr_d[fill_idx] = ptr_q[fill_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= vld_d[s];
        ptr_q[s] <= ptr_d[s];
      end
    end
  end

  // Mapping payload: no reset, written under enable only.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[fill_idx][victim]  <= fill_tag;
      ppn_q[fill_idx][victim]  <= fill_ppn;
      perm_q[fill_idx][victim] <= fill_perm;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_valid[w] = vld_q[rd_idx][w];
    assign rd_tag[w]   = tag_q[rd_idx][w];
    assign rd_ppn[w]   = ppn_q[rd_idx][w];
    assign rd_perm[w]  = perm_q[rd_idx][w];
  end

endmodule

// File: rtl/vtrans_match.sv
module vtrans_match #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 18,
  parameter int PPN_W  = 20,
  parameter int PERM_W = 4
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]  way_ppn,
  input  logic [WAYS-1:0][PERM_W-1:0] way_perm,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic                        hit,
  output logic [PPN_W-1:0]            hit_ppn,
  output logic [PERM_W-1:0]           hit_perm
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == lk_tag);
  end

  assign hit = |hit_vec;

  // At most one way matches, so an OR of masked payloads selects it.
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_ppn  = hit_ppn  | (way_ppn[w]  & {PPN_W{hit_vec[w]}});
      hit_perm = hit_perm | (way_perm[w] & {PERM_W{hit_vec[w]}});
    end
  end

endmodule

// File: rtl/vtrans_perm.sv
module vtrans_perm
  import vtrans_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic [1:0]        kind,
  input  logic              user,
  output logic              allow
);

  assign allow = rights_allow(perm, kind, user);

endmodule

// File: rtl/vtrans_tlb.sv
module vtrans_tlb
  import vtrans_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PG_W  = 12,
  parameter int IDX_W = 2,
  parameter int WAYS  = 2,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PPN_W = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             refill_req,
  output logic [VPN_W-1:0] refill_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic             flush
);

  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0]            lk_idx;
  logic [TAG_W-1:0]            lk_tag;
  logic [WAYS-1:0]             set_valid;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0][PPN_W-1:0]  set_ppn;
  logic [WAYS-1:0][PERM_W-1:0] set_perm;
  logic                        any_hit;
  logic [PPN_W-1:0]            sel_ppn;
  logic [PERM_W-1:0]           sel_perm;
  logic                        allowed;

  assign lk_idx = req_vaddr[PG_W +: IDX_W];
  assign lk_tag = req_vaddr[VA_W-1 : PG_W+IDX_W];

  vtrans_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PPN_W(PPN_W), .PERM_W(PERM_W), .WAY_W(WAY_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_valid  (set_valid),
    .rd_tag    (set_tag),
    .rd_ppn    (set_ppn),
    .rd_perm   (set_perm),
    .fill_en   (fill_valid),
    .flush_en  (flush),
    .fill_idx  (fill_vpn[IDX_W-1:0]),
    .fill_tag  (fill_vpn[VPN_W-1:IDX_W]),
    .fill_ppn  (fill_ppn),
    .fill_perm (fill_perm)
  );

  vtrans_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_match (
    .way_valid (set_valid),
    .way_tag   (set_tag),
    .way_ppn   (set_ppn),
    .way_perm  (set_perm),
    .lk_tag    (lk_tag),
    .hit       (any_hit),
    .hit_ppn   (sel_ppn),
    .hit_perm  (sel_perm)
  );

  vtrans_perm u_perm (
    .perm  (sel_perm),
    .kind  (req_kind),
    .user  (req_user),
    .allow (allowed)
  );

  // Response next state.
  logic             vld_d, hit_d, miss_d, flt_d;
  logic [PA_W-1:0]  pa_d;
  logic [VPN_W-1:0] rvpn_d;

  always_comb begin
    vld_d  = req_valid;
    hit_d  = req_valid &  any_hit &  allowed;
    flt_d  = req_valid &  any_hit & ~allowed;
    miss_d = req_valid & ~any_hit;
    pa_d   = hit_d  ? {sel_ppn, req_vaddr[PG_W-1:0]} : '0;
    rvpn_d = miss_d ? req_vaddr[VA_W-1:PG_W]         : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_paddr  <= '0;
      refill_vpn <= '0;
    end else begin
      rsp_valid  <= vld_d;
      rsp_hit    <= hit_d;
      rsp_miss   <= miss_d;
      rsp_fault  <= flt_d;
      rsp_paddr  <= pa_d;
      refill_vpn <= rvpn_d;
    end
  end

  assign refill_req = rsp_miss;

endmodule

// File: rtl/vtrans_tlb_chk.sv
module vtrans_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int PG_W = 12,
  localparam int VPN_W = VA_W - PG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [VPN_W-1:0] refill_vpn,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             flush
);

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0));

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[PG_W-1:0] == $past(req_vaddr[PG_W-1:0]));

  p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  p_refill_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> refill_vpn == $past(req_vaddr[VA_W-1:PG_W]));

  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) ##1 (req_valid && req_vaddr[VA_W-1:PG_W] == $past(fill_vpn))
      |=> !rsp_miss);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_valid |=> rsp_miss);

endmodule

bind vtrans_tlb vtrans_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_chk (.*);

// File: tb/vtrans_tlb_bench.sv
`timescale 1ns/1ps
module vtrans_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, refill_req;
  logic [31:0] rsp_paddr;
  logic [19:0] refill_vpn;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_ppn;
  logic [3:0]  fill_perm;
  logic        flush;

  always #4 clk = ~clk;

  vtrans_tlb u_vtrans_tlb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .refill_req(refill_req), .refill_vpn(refill_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .flush(flush)
  );

  // Behavioural reference state.
  bit          m_v    [4][2];
  int unsigned m_tag  [4][2];
  int unsigned m_ppn  [4][2];
  int unsigned m_perm [4][2];
  int          m_ptr  [4];

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  // Packed outcome: valid,hit,miss,fault,refill,paddr,refill_vpn
  function automatic logic [56:0] predict(bit rv, logic [31:0] va, logic [1:0] kind, bit usr);
    int s; int unsigned t; bit fnd; int unsigned pp; int unsigned pm; bit ok;
    logic [56:0] r;
    r = '0;
    if (!rv) return r;
    s = int'(va[13:12]); t = va[31:14]; fnd = 0; pp = 0; pm = 0;
    for (int w = 0; w < 2; w++)
      if (m_v[s][w] && m_tag[s][w] == t) begin fnd = 1; pp = m_ppn[s][w]; pm = m_perm[s][w]; end
    r[56] = 1'b1;
    if (!fnd) begin
      r[54] = 1'b1; r[52] = 1'b1; r[19:0] = va[31:12];
    end else begin
      ok = (kind == 2'd0) ? pm[0] : (kind == 2'd1) ? pm[1] : (kind == 2'd2) ? pm[2] : 1'b0;
      if (usr && !pm[3]) ok = 0;
      if (ok) begin r[55] = 1'b1; r[51:20] = {pp[19:0], va[11:0]}; end
      else      r[53] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_update(bit fv, logic [19:0] vpn, logic [19:0] ppn, logic [3:0] perm, bit fl);
    int s; int unsigned t; int way; bit got;
    if (fl) begin
      for (int a = 0; a < 4; a++) for (int b = 0; b < 2; b++) m_v[a][b] = 0;
      return;
    end
    if (!fv) return;
    s = int'(vpn[1:0]); t = vpn[19:2]; got = 0; way = 0;
    for (int w = 0; w < 2; w++) if (!got && m_v[s][w] && m_tag[s][w] == t) begin got = 1; way = w; end
    for (int w = 0; w < 2; w++) if (!got && !m_v[s][w]) begin got = 1; way = w; end
    if (!got) begin way = m_ptr[s]; m_ptr[s] = (m_ptr[s] + 1) % 2; end
    m_v[s][way] = 1; m_tag[s][way] = t; m_ppn[s][way] = ppn; m_perm[s][way] = perm;
  endtask

  task automatic compare(string tag, logic [56:0] exp);
    logic [56:0] act;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, refill_req, rsp_paddr, refill_vpn};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (v,h,m,f,rr,pa,rvpn)", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, clock, compare at next negedge.
  task automatic step(string tag, bit rv, logic [31:0] va, logic [1:0] kind, bit usr,
                      bit fv, logic [19:0] fvpn, logic [19:0] fppn, logic [3:0] fperm, bit fl);
    logic [56:0] exp;
    req_valid = rv; req_vaddr = va; req_kind = kind; req_user = usr;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm; flush = fl;
    exp = predict(rv, va, kind, usr);
    @(posedge clk);
    model_update(fv, fvpn, fppn, fperm, fl);
    @(negedge clk);
    compare(tag, exp);
  endtask

  task automatic look(string tag, logic [31:0] va, logic [1:0] kind, bit usr);
    step(tag, 1, va, kind, usr, 0, '0, '0, '0, 0);
  endtask

  task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn, logic [3:0] perm);
    step(tag, 0, '0, 0, 0, 1, vpn, ppn, perm, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; req_kind = '0; req_user = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0; flush = 0;
    for (int a = 0; a < 4; a++) begin
      m_ptr[a] = 0;
      for (int b = 0; b < 2; b++) begin m_v[a][b] = 0; m_tag[a][b] = 0; m_ppn[a][b] = 0; m_perm[a][b] = 0; end
    end
    repeat (3) @(negedge clk);
    compare("R11 reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 after release", '0);

    step("R1 idle", 0, '0, 0, 0, 0, '0, '0, '0, 0);
    look("R6 cold miss", 32'h0001_2345, 2'd0, 0);
    // Fill and same-cycle lookup of that page: old contents seen.
    step("R7 same-cycle fill", 1, 32'h0001_2345, 2'd0, 0, 1, 20'h00012, 20'hABCDE, 4'b1111, 0);
    look("R4 read hit", 32'h0001_2345, 2'd0, 0);
    look("R4 other offset", 32'h0001_2FFF, 2'd1, 1);
    look("R2 neighbour set", 32'h0001_3345, 2'd0, 0);
    look("R2 tag differs", 32'h0005_2345, 2'd0, 0);

    fill("R5 read-only fill", 20'h00034, 20'h12345, 4'b0001);
    look("R5 read ok", 32'h0003_4010, 2'd0, 0);
    look("R5 write denied", 32'h0003_4010, 2'd1, 0);
    look("R5 exec denied", 32'h0003_4010, 2'd2, 0);
    look("R5 user denied", 32'h0003_4010, 2'd0, 1);
    look("R5 reserved kind", 32'h0003_4010, 2'd3, 0);
    look("R3 back-to-back", 32'h0003_4FFC, 2'd0, 0);

    // Set 2 holds page 0x00012; re-fill it, then crowd the set.
    fill("R8 same page refill", 20'h00012, 20'h11111, 4'b0011);
    look("R8 new mapping", 32'h0001_2004, 2'd1, 0);
    fill("R9 empty way", 20'h00016, 20'h22222, 4'b0111);
    look("R9 first kept", 32'h0001_2008, 2'd0, 0);
    look("R9 second present", 32'h0001_6008, 2'd2, 0);
    fill("R9 evict ptr 0", 20'h0001A, 20'h33333, 4'b1111);
    look("R9 evicted way0", 32'h0001_2008, 2'd0, 0);
    look("R9 way1 kept", 32'h0001_6008, 2'd0, 0);
    fill("R9 evict ptr 1", 20'h0001E, 20'h44444, 4'b1111);
    look("R9 evicted way1", 32'h0001_6008, 2'd0, 0);
    look("R9 newest", 32'h0001_E100, 2'd0, 1);

    // Flush with fill and lookup in the same cycle.
    step("R10 flush cycle", 1, 32'h0001_E100, 2'd0, 0, 1, 20'h00055, 20'h55555, 4'b1111, 1);
    look("R10 flushed", 32'h0001_E100, 2'd0, 0);
    look("R10 fill dropped", 32'h0005_5000, 2'd0, 0);
    look("R10 other flushed", 32'h0001_A000, 2'd0, 0);

    // Mixed traffic over a crowded page pool.
    for (int i = 0; i < 4000; i++) begin
      logic [19:0] pv, fvp;
      pv  = {16'h0, 4'($urandom)};
      fvp = {16'h0, 4'($urandom)};
      step("R3 mixed", ($urandom % 4) != 0, {pv, 12'($urandom)}, 2'($urandom), 1'($urandom),
           ($urandom % 3) == 0, fvp, 20'($urandom), 4'($urandom), ($urandom % 97) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule